// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns internal read and write requests of a small 8-bit processor core into external bus cycles. A request names a 16-bit address, a direction and a space (memory or I/O port). The sequencer then runs one machine cycle on the pins: a first period that presents the low address byte on the shared address/data bus together with an address strobe, followed by data periods in which a read or write strobe is active. Slow devices stretch the data phase by pulling the ready input low. Another bus master can claim the bus through a hold request. The sequencer grants it only after the cycle in progress has finished.

The shared bus and the control outputs are modelled as value/enable pairs so that the pad ring can build the three-state drivers. `ad_oe` enables the shared bus drivers. `ctl_oe` enables the upper address byte, the address strobe, the memory/IO select and both read/write strobes. When the hold is released, the acknowledge falls on a rising clock edge and the sequencer drives its pins again on the following falling edge.

Top module: `mbus_sequencer`

## Requirements
- R1: While reset is asserted, `hlda`=0, `ctl_oe`=0, `ad_oe`=0, `ale`=0, `rd_n`=1 and `wr_n`=1. Once reset is released, `ctl_oe` rises by the end of the first clock period.
- R2: `req_take` is high in an idle cycle in which `req_valid`=1 and `hold`=0. The next cycle is the address period: for exactly one cycle `ale`=1, `ad_oe`=1 and `ad_out` equals address bits 7:0.
- R3: `io_m` is 1 for a port cycle and 0 for a memory cycle, and it stays constant from the address period through the last strobe cycle.
- R4: For memory cycles, `a_hi` carries address bits 15:8. For port cycles, `a_hi` carries the 8-bit port number (address bits 7:0), which also appears on `ad_out`.
- R5: In a read, `rd_n` is 0 from the cycle after the address period through the final data cycle, and `ad_oe` is 0 throughout. `rdata` holds the `ad_in` value of the final strobe-low cycle.
- R6: In a write, `wr_n` is 0 for the same span, and `ad_oe`=1 with `ad_out` equal to the write data while `wr_n` is 0. `ad_oe` is 0 in every cycle that is neither an address period nor a write strobe cycle.
- R7: In the first data cycle and in each wait cycle, `ready` is sampled at the closing clock edge. Each low sample adds one more strobe-low cycle, so the strobe is low for 2 + (number of low samples) cycles.
- R8: With `hold`=1 in an idle cycle, `hlda` is 1 from the next cycle on. While `hlda`=1, `ctl_oe`=0, `ad_oe`=0, `req_take`=0 and no address period starts.
- R9: A `hold` raised during a bus cycle does not shorten the cycle. `hlda` stays 0 until the cycle after the last strobe-low cycle.
- R10: One clock edge after `hold` returns to 0, `hlda` is 0 and `ctl_oe` is still 0. `ctl_oe` returns to 1 half a clock period later.
- R11: `done` is a one-cycle pulse in the cycle after the last strobe-low cycle of every read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | internal request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = port space, 0 = memory |
| req_addr | input | 16 | request address (port number in bits 7:0) |
| req_wdata | input | 8 | write data |
| req_take | output | 1 | request accepted this cycle |
| done | output | 1 | cycle finished pulse |
| rdata | output | 8 | captured read data |
| ad_in | input | 8 | shared bus input value |
| ad_out | output | 8 | shared bus drive value |
| ad_oe | output | 1 | shared bus drive enable |
| a_hi | output | 8 | upper address byte |
| ale | output | 1 | address latch strobe |
| io_m | output | 1 | 1 = port, 0 = memory |
| rd_n | output | 1 | read strobe, active low |
| wr_n | output | 1 | write strobe, active low |
| ctl_oe | output | 1 | drive enable for upper address and control outputs |
| ready | input | 1 | 0 inserts wait states |
| hold | input | 1 | bus request from another master |
| hlda | output | 1 | bus granted to the other master |

## Verification
The assertions assume that `ready` and `hold` are synchronous to the clock and are stable around the rising edge. They also assume that request fields are held steady while `req_valid` waits in an idle cycle. The bench changes every input at one fixed point late in the clock period, after the falling edge, and drops `req_valid` as soon as the request is taken. Random wait counts and hold requests are applied only through `ready` and `hold` at that same point, so every sampled input meets these assumptions.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_HOLD
  } bus_st_e;
endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    ready,
  input  logic    hold,
  output bus_st_e st,
  output logic    take,
  output logic    done,
  output logic    hlda
);

  bus_st_e st_q, st_d;
  logic    done_q, done_d;

  // next-state decode
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold)           st_d = ST_HOLD;
        else if (req_valid) st_d = ST_T1;
      end
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ready ? ST_T3 : ST_TW;
      ST_TW:   st_d = ready ? ST_T3 : ST_TW;
      ST_T3:   st_d = hold ? ST_HOLD : ST_IDLE;
      ST_HOLD: st_d = hold ? ST_HOLD : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign done_d = (st_q == ST_T3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign st   = st_q;
  assign take = (st_q == ST_IDLE) && req_valid && !hold;
  assign done = done_q;
  assign hlda = (st_q == ST_HOLD);

  // R2: the address period lasts one cycle
  a_r2_addr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T1) |=> (st_q == ST_T2));

  // R7: a low ready in a data cycle forces a wait cycle
  a_r7_wait_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_T2 || st_q == ST_TW) && !ready) |=> (st_q == ST_TW));

  // R9: no grant before the cycle has finished
  a_r9_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T1 || st_q == ST_T2 || st_q == ST_TW) |=> (st_q != ST_HOLD));

  // R11: the completion pulse is one cycle long
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_e           st,
  input  logic              take,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] rdata
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              cyc_wr_q, cyc_io_q;
  logic [ADDR_W-1:0] cyc_addr_q;
  logic [DATA_W-1:0] cyc_wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cap_en, data_ph;

  assign cap_en  = (st == ST_T3) && !cyc_wr_q;
  assign data_ph = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);

  // request capture, enabled by take
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_wr_q    <= 1'b0;
      cyc_io_q    <= 1'b0;
      cyc_addr_q  <= '0;
      cyc_wdata_q <= '0;
    end else if (take) begin
      cyc_wr_q    <= req_write;
      cyc_io_q    <= req_io;
      cyc_addr_q  <= req_addr;
      cyc_wdata_q <= req_wdata;
    end
  end

  // read capture at the close of the final strobe cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

  assign ale    = (st == ST_T1);
  assign rd_n   = !(data_ph && !cyc_wr_q);
  assign wr_n   = !(data_ph && cyc_wr_q);
  assign ad_oe  = ale || (data_ph && cyc_wr_q);
  assign ad_out = ale ? cyc_addr_q[DATA_W-1:0] : cyc_wdata_q;
  assign io_m   = cyc_io_q;
  assign rdata  = rdata_q;

  generate
    if (HI_W == DATA_W) begin : g_hi_same
      assign a_hi = cyc_io_q ? cyc_addr_q[DATA_W-1:0] : cyc_addr_q[ADDR_W-1:DATA_W];
    end else begin : g_hi_cast
      assign a_hi = cyc_io_q ? HI_W'(cyc_addr_q[DATA_W-1:0]) : cyc_addr_q[ADDR_W-1:DATA_W];
    end
  endgenerate

  // R5: the bus floats while the read strobe is low
  a_r5_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6: write data is driven whenever the write strobe is low
  a_r6_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && ad_out == cyc_wdata_q));

  // R3: space select does not move during the strobe phase
  a_r3_io_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(io_m));

  // R5, R6: never both strobes
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n);

endmodule

// File: rtl/mbus_takeback.sv
module mbus_takeback (
  input  logic clk,
  input  logic rst_n,
  input  logic hlda,
  output logic ctl_oe
);

  logic own_q;

  // falling-edge flop: the drive returns half a period after hlda drops
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= 1'b0;
    else        own_q <= !hlda;
  end

  assign ctl_oe = own_q && !hlda;

  // R10: no drive while the grant is active
  a_r10_no_early_drive: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !ctl_oe);

endmodule

// File: rtl/mbus_sequencer.sv
module mbus_sequencer
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_take,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ctl_oe,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);

  localparam int HI_W = ADDR_W - DATA_W;

  bus_st_e st;
  logic    take;

  mbus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .hold      (hold),
    .st        (st),
    .take      (take),
    .done      (done),
    .hlda      (hlda)
  );

  mbus_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .take      (take),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .ale       (ale),
    .io_m      (io_m),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rdata     (rdata)
  );

  mbus_takeback u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .hlda   (hlda),
    .ctl_oe (ctl_oe)
  );

  assign req_take = take;

  // R8: all drivers off while the bus is granted
  a_r8_granted_float: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ctl_oe && !ad_oe && !req_take && !ale));

  // R4: port number on both address bytes
  a_r4_port_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && io_m) |-> (a_hi == HI_W'(ad_out)));

  // R9: an address period is never followed directly by a grant
  a_r9_no_grant_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !hlda);

endmodule

// File: tb/mbus_sequencer_tb.sv
`timescale 1ns/100ps
module mbus_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_io;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_take, done;
  logic [7:0]  rdata, ad_in, ad_out;
  logic        ad_oe, ale, io_m, rd_n, wr_n, ctl_oe;
  logic [7:0]  a_hi;
  logic        ready, hold, hlda;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mbus_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_take(req_take), .done(done), .rdata(rdata), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe), .ready(ready), .hold(hold),
    .hlda(hlda)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] hi_exp(input bit io, input logic [15:0] a);
    return io ? a[7:0] : a[15:8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // starts at a sample point in an idle cycle
  task automatic run_cyc(input bit wr, input bit io, input logic [15:0] addr,
                         input logic [7:0] wd, input int waits, input bit hold_mid);
    logic [7:0] rexp;
    rexp = mem_fn(addr);
    req_valid = 1; req_write = wr; req_io = io; req_addr = addr; req_wdata = wd;
    ad_in = rexp; hold = 0;
    #0.5;
    chk("R2 take", req_take, 1);
    @(posedge clk); #4;
    chk("R2 ale", ale, 1);
    chk("R2 ad_oe", ad_oe, 1);
    chk("R2 ad_out", ad_out, addr[7:0]);
    chk("R3 io_m", io_m, io);
    chk("R4 a_hi", a_hi, hi_exp(io, addr));
    chk("R5 R6 strobes idle in T1", {rd_n, wr_n}, 2'b11);
    req_valid = 0;
    if (hold_mid) hold = 1;
    for (int i = 0; i <= waits; i++) begin
      @(posedge clk); #4;
      chk("R7 strobe low", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
      chk(wr ? "R6 ad_oe" : "R5 ad_oe", ad_oe, wr);
      if (wr) chk("R6 ad_out", ad_out, wd);
      chk("R2 ale once", ale, 0);
      chk("R3 io_m", io_m, io);
      chk("R9 no early grant", hlda, 0);
      ready = (i >= waits);
    end
    @(posedge clk); #4;
    chk("R7 final strobe", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
    chk("R9 no early grant", hlda, 0);
    ready = 1;
    @(posedge clk); #4;
    chk("R7 strobe ends", {rd_n, wr_n}, 2'b11);
    chk("R6 ad_oe off", ad_oe, 0);
    chk("R11 done", done, 1);
    if (!wr) chk("R5 rdata", rdata, rexp);
    chk("R9 grant after cycle", hlda, hold_mid);
    if (hold_mid) chk("R8 ctl_oe off", ctl_oe, 0);
    @(posedge clk); #4;
    chk("R11 done pulse", done, 0);
  endtask

  task automatic release_hold();
    hold = 0;
    @(posedge clk); #1;
    chk("R10 hlda falls", hlda, 0);
    chk("R10 still released", ctl_oe, 0);
    #3;
    chk("R10 drive back", ctl_oe, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_io = 0; req_addr = '0;
    req_wdata = '0; ad_in = '0; ready = 1; hold = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #4;
    chk("R1 hlda", hlda, 0);
    chk("R1 ctl_oe", ctl_oe, 0);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n}, 2'b11);
    rst_n = 1;
    @(posedge clk); #4;
    chk("R1 ctl_oe after release", ctl_oe, 1);

    // directed: memory read, memory write, port read, port write
    run_cyc(0, 0, 16'h12A4, 8'h00, 0, 0);
    run_cyc(1, 0, 16'hBEEF, 8'hC3, 0, 0);
    run_cyc(0, 1, 16'h7733, 8'h00, 0, 0);
    run_cyc(1, 1, 16'h0081, 8'h5E, 2, 0);
    // R7: long wait
    run_cyc(0, 0, 16'hFFFF, 8'h00, 5, 0);

    // R8: hold in idle, request pending but refused
    hold = 1; req_valid = 1; req_addr = 16'h1111;
    #0.5;
    chk("R8 no take under hold", req_take, 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #4;
      chk("R8 hlda", hlda, 1);
      chk("R8 ctl_oe", ctl_oe, 0);
      chk("R8 ad_oe", ad_oe, 0);
      chk("R8 no ale", ale, 0);
      chk("R8 no take", req_take, 0);
    end
    req_valid = 0;
    release_hold();

    // R9: hold raised during a write with waits
    run_cyc(1, 0, 16'h4321, 8'hA5, 1, 1);
    release_hold();

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit          w, io, hm;
      logic [15:0] a;
      logic [7:0]  d;
      int          wt;
      w  = 1'($urandom_range(0, 1));
      io = 1'($urandom_range(0, 1));
      a  = 16'($urandom());
      d  = 8'($urandom());
      wt = $urandom_range(0, 3);
      hm = ($urandom_range(0, 4) == 0);
      run_cyc(w, io, a, d, wt, hm);
      if (hm) release_hold();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule